// File: doc/BRIEF.md
# Branch-Broadcast Region Filter

This block decides, for each retired instruction address handed to it, whether branch broadcasting should be active for that instruction. It holds a small set of address range comparators, each with a programmable inclusive low and high bound, and one control register. The control register picks which comparators take part in the decision and whether the chosen ranges are regions to include or regions to exclude. A global enable input, driven from the trace unit's main configuration, qualifies every result.

Software reaches the control register and the bound registers through a simple debug register port. Each request is answered one cycle later with read data and an error flag. Accesses fail with an error when the OS lock is held, when external trace access is not allowed, or when the trace core is powered down. Writes also fail while the trace unit is not idle, and a failed write changes nothing.

Addresses flow in on a valid/ready stream, and results flow out on another. A result is held stable while `out_ready` is low. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. An address is accepted on a cycle where `in_valid` and `in_ready` are both high. The debug port has no back-pressure.

Top module: `bbc_region_filter`

## Requirements
- R1: Comparator m matches an address when low bound m <= address <= high bound m, with both bounds inclusive and compared unsigned. Control bit m (bits [NUM_CMP-1:0]) selects comparator m into the decision.
- R2: With control bit 8 = 0 (exclude), the result is active when no selected comparator matches. If no comparator is selected, every address is active.
- R3: With control bit 8 = 1 (include), the result is active only when at least one selected comparator matches. If no comparator is selected, no address is active.
- R4: Control bits [31:9] read as zero, and writing them has no effect.
- R5: Control select bits from NUM_CMP up to bit 7 read as zero and have no effect on the decision.
- R6: The control register is at offset 0x03C. The low bound of comparator m is at 0x100+8*m and its high bound is at 0x104+8*m, both reset to zero. Any other offset answers with an error, and an errored read returns zero.
- R7: Any access made while `os_lock` is 1, `ext_access_ok` is 0 or `core_powered` is 0 answers with an error, and a write made this way is discarded.
- R8: A write made while `unit_idle` is 0 answers with an error and leaves every register unchanged. Reads still succeed in that state.
- R9: Every debug request gets exactly one response, with `dbg_rsp_valid` high in the cycle after the request.
- R10: A result appears on `out_valid`/`out_active` in the cycle after its address is accepted. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, the output holds.
- R11: `out_active` is 0 for any address accepted while `bb_enable` is 0.
- R12: Reset clears the control register, the bound registers and `out_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bb_enable | input | 1 | Global branch-broadcast enable |
| unit_idle | input | 1 | Trace unit is idle; writes allowed |
| os_lock | input | 1 | OS lock held; all accesses error |
| ext_access_ok | input | 1 | External trace access permitted |
| core_powered | input | 1 | Trace core power is up |
| dbg_req_valid | input | 1 | Debug request strobe |
| dbg_req_write | input | 1 | 1 = write, 0 = read |
| dbg_req_ofs | input | 12 | Register byte offset |
| dbg_req_wdata | input | 32 | Write data |
| dbg_rsp_valid | output | 1 | Response strobe, one cycle after request |
| dbg_rsp_err | output | 1 | Response carries an error |
| dbg_rsp_rdata | output | 32 | Read data, zero on error or write |
| in_valid | input | 1 | Address stream valid |
| in_ready | output | 1 | Address stream ready |
| in_addr | input | ADDR_W | Retired instruction address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_active | output | 1 | Branch broadcasting active for the address |

## Verification
Some properties are checked on every cycle: the response timing, error responses under lock, access-denied or power-down, configuration that does not change across a write rejected while busy, reserved control bits that read as zero, output hold under back-pressure, and results forced low while the enable is off. The region decision itself is shown only by the bench scenarios. These include the inclusive bound edges, both modes with empty and non-empty selections, reserved select bits that have no effect, and random configurations checked against a reference function.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned OFS_W    = 12;
  localparam int unsigned MODE_BIT = 8;
  localparam logic [OFS_W-1:0] CTRL_OFS   = 12'h03C;
  localparam logic [OFS_W-1:0] BOUND_BASE = 12'h100;
  localparam int unsigned BOUND_STRIDE = 8;
endpackage

// File: rtl/bbc_range_cmp.sv
module bbc_range_cmp #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              en,
  output logic              hit
);
  logic above_lo, below_hi;
  assign above_lo = (addr >= lo);
  assign below_hi = (addr <= hi);
  assign hit      = en && above_lo && below_hi;
endmodule

// File: rtl/bbc_decide.sv
module bbc_decide #(
  parameter int unsigned NUM_CMP = 6
) (
  input  logic [NUM_CMP-1:0] hits,
  input  logic               include_mode,
  input  logic               enable,
  output logic               active
);
  logic any_hit;
  assign any_hit = |hits;
  // Include with empty selection gives no hits -> inactive; exclude -> active.
  assign active = enable && (include_mode ? any_hit : !any_hit);
endmodule

// File: rtl/bbc_regs.sv
module bbc_regs
  import bbc_pkg::*;
#(
  parameter int unsigned NUM_CMP = 6,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      unit_idle,
  input  logic                      os_lock,
  input  logic                      ext_access_ok,
  input  logic                      core_powered,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [OFS_W-1:0]          req_ofs,
  input  logic [REG_W-1:0]          req_wdata,
  output logic                      rsp_valid,
  output logic                      rsp_err,
  output logic [REG_W-1:0]          rsp_rdata,
  output logic [NUM_CMP-1:0]        cfg_sel,
  output logic                      cfg_mode,
  output logic [NUM_CMP*ADDR_W-1:0] lo_flat,
  output logic [NUM_CMP*ADDR_W-1:0] hi_flat
);
  localparam int unsigned IDX_W    = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
  localparam int unsigned BND_SPAN = BOUND_STRIDE * NUM_CMP;

  logic               blocked;
  logic               hit_ctrl;
  logic               hit_bnd;
  logic [OFS_W-1:0]   rel;
  logic [IDX_W-1:0]   bidx;
  logic               bnd_hi;
  logic               acc_err;
  logic               wr_ok;
  logic [REG_W-1:0]   rd_mux;

  logic [NUM_CMP-1:0] sel_q;
  logic               mode_q;
  logic [ADDR_W-1:0]  lo_q [NUM_CMP];
  logic [ADDR_W-1:0]  hi_q [NUM_CMP];

  assign blocked  = os_lock || !ext_access_ok || !core_powered;
  assign rel      = req_ofs - BOUND_BASE;
  assign hit_ctrl = (req_ofs == CTRL_OFS);
  assign hit_bnd  = (req_ofs >= BOUND_BASE) && (rel < OFS_W'(BND_SPAN)) &&
                    (rel[1:0] == 2'b00);
  assign bidx     = rel[IDX_W+2:3];
  assign bnd_hi   = rel[2];
  assign acc_err  = blocked || !(hit_ctrl || hit_bnd) || (req_write && !unit_idle);
  assign wr_ok    = req_valid && req_write && !acc_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= 1'b0;
    end else if (wr_ok && hit_ctrl) begin
      sel_q  <= req_wdata[NUM_CMP-1:0];
      mode_q <= req_wdata[MODE_BIT];
    end
  end

  for (genvar m = 0; m < NUM_CMP; m++) begin : g_bound
    logic sel_this;
    assign sel_this = wr_ok && hit_bnd && (bidx == IDX_W'(m));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[m] <= '0;
        hi_q[m] <= '0;
      end else if (sel_this) begin
        if (bnd_hi) hi_q[m] <= req_wdata[ADDR_W-1:0];
        else        lo_q[m] <= req_wdata[ADDR_W-1:0];
      end
    end
    assign lo_flat[m*ADDR_W +: ADDR_W] = lo_q[m];
    assign hi_flat[m*ADDR_W +: ADDR_W] = hi_q[m];
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[NUM_CMP-1:0] = sel_q;
      rd_mux[MODE_BIT]    = mode_q;
    end else if (hit_bnd) begin
      for (int m = 0; m < NUM_CMP; m++) begin
        if (bidx == IDX_W'(m)) rd_mux[ADDR_W-1:0] = bnd_hi ? hi_q[m] : lo_q[m];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && acc_err;
      rsp_rdata <= (req_valid && !req_write && !acc_err) ? rd_mux : '0;
    end
  end

  assign cfg_sel  = sel_q;
  assign cfg_mode = mode_q;
endmodule

// File: rtl/bbc_region_filter.sv
module bbc_region_filter
  import bbc_pkg::*;
#(
  parameter int unsigned NUM_CMP = 6,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bb_enable,
  input  logic              unit_idle,
  input  logic              os_lock,
  input  logic              ext_access_ok,
  input  logic              core_powered,
  input  logic              dbg_req_valid,
  input  logic              dbg_req_write,
  input  logic [11:0]       dbg_req_ofs,
  input  logic [31:0]       dbg_req_wdata,
  output logic              dbg_rsp_valid,
  output logic              dbg_rsp_err,
  output logic [31:0]       dbg_rsp_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_active
);
  logic [NUM_CMP-1:0]        cfg_sel;
  logic                      cfg_mode;
  logic [NUM_CMP*ADDR_W-1:0] lo_flat;
  logic [NUM_CMP*ADDR_W-1:0] hi_flat;
  logic [NUM_CMP-1:0]        hits;
  logic                      decision;
  logic                      accept;
  logic                      out_valid_q;
  logic                      out_active_q;

  bbc_regs #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .unit_idle    (unit_idle),
    .os_lock      (os_lock),
    .ext_access_ok(ext_access_ok),
    .core_powered (core_powered),
    .req_valid    (dbg_req_valid),
    .req_write    (dbg_req_write),
    .req_ofs      (dbg_req_ofs),
    .req_wdata    (dbg_req_wdata),
    .rsp_valid    (dbg_rsp_valid),
    .rsp_err      (dbg_rsp_err),
    .rsp_rdata    (dbg_rsp_rdata),
    .cfg_sel      (cfg_sel),
    .cfg_mode     (cfg_mode),
    .lo_flat      (lo_flat),
    .hi_flat      (hi_flat)
  );

  for (genvar m = 0; m < NUM_CMP; m++) begin : g_cmp
    bbc_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .addr(in_addr),
      .lo  (lo_flat[m*ADDR_W +: ADDR_W]),
      .hi  (hi_flat[m*ADDR_W +: ADDR_W]),
      .en  (cfg_sel[m]),
      .hit (hits[m])
    );
  end

  bbc_decide #(.NUM_CMP(NUM_CMP)) u_decide (
    .hits        (hits),
    .include_mode(cfg_mode),
    .enable      (bb_enable),
    .active      (decision)
  );

  assign in_ready = !out_valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q  <= 1'b0;
      out_active_q <= 1'b0;
    end else if (accept) begin
      out_valid_q  <= 1'b1;
      out_active_q <= decision;
    end else if (out_ready) begin
      out_valid_q  <= 1'b0;
    end
  end

  assign out_valid  = out_valid_q;
  assign out_active = out_active_q;
endmodule

// File: rtl/bbc_region_filter_chk.sv
module bbc_region_filter_chk
  import bbc_pkg::*;
#(
  parameter int unsigned NUM_CMP = 6,
  parameter int unsigned ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bb_enable,
  input logic               unit_idle,
  input logic               os_lock,
  input logic               ext_access_ok,
  input logic               core_powered,
  input logic               dbg_req_valid,
  input logic               dbg_req_write,
  input logic [11:0]        dbg_req_ofs,
  input logic [31:0]        dbg_rsp_rdata,
  input logic               dbg_rsp_valid,
  input logic               dbg_rsp_err,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_active,
  input logic [NUM_CMP-1:0] cfg_sel,
  input logic               cfg_mode
);
  localparam logic [31:0] LIVE_MASK = 32'h100 | ((32'h1 << NUM_CMP) - 32'h1);

  p_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_valid |=> dbg_rsp_valid);
  p_rsp_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_req_valid |=> !dbg_rsp_valid);
  p_gate_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_valid && (os_lock || !ext_access_ok || !core_powered)) |=> dbg_rsp_err);
  p_busy_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_valid && dbg_req_write && !unit_idle) |=>
      (dbg_rsp_err && $stable(cfg_sel) && $stable(cfg_mode)));
  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_valid && !dbg_req_write && dbg_req_ofs == CTRL_OFS) |=>
      ((dbg_rsp_rdata & ~LIVE_MASK) == 32'h0));
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_active)));
  p_ready_rule_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid) |-> in_ready);
  p_enable_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !bb_enable) |=> (out_valid && !out_active));
endmodule

bind bbc_region_filter bbc_region_filter_chk #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_bbc_region_filter.sv
module test_bbc_region_filter;
  localparam int NC = 6;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bb_enable = 1'b1, unit_idle = 1'b1, os_lock = 1'b0;
  logic ext_access_ok = 1'b1, core_powered = 1'b1;
  logic dbg_req_valid = 1'b0, dbg_req_write = 1'b0;
  logic [11:0] dbg_req_ofs = '0;
  logic [31:0] dbg_req_wdata = '0;
  logic dbg_rsp_valid, dbg_rsp_err;
  logic [31:0] dbg_rsp_rdata;
  logic in_valid = 1'b0, in_ready;
  logic [AW-1:0] in_addr = '0;
  logic out_valid, out_ready = 1'b1, out_active;

  always #2 clk = ~clk;

  bbc_region_filter #(.NUM_CMP(NC), .ADDR_W(AW)) i_bbc_region_filter (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  logic [NC-1:0] m_sel = '0;
  logic m_mode = 1'b0;
  logic [AW-1:0] m_lo [NC];
  logic [AW-1:0] m_hi [NC];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [11:0] ofs);
    return (ofs == 12'h03C) ||
           (ofs >= 12'h100 && ofs < 12'(12'h100 + 8*NC) && ofs[1:0] == 2'b00);
  endfunction

  function automatic bit exp_err(input bit wr, input logic [11:0] ofs);
    return os_lock || !ext_access_ok || !core_powered || !mapped(ofs) || (wr && !unit_idle);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] ofs);
    logic [31:0] v = '0;
    int idx;
    if (ofs == 12'h03C) begin
      v[NC-1:0] = m_sel;
      v[8] = m_mode;
    end else begin
      idx = int'(ofs - 12'h100) / 8;
      v = ofs[2] ? m_hi[idx] : m_lo[idx];
    end
    return v;
  endfunction

  function automatic bit model_active(input logic [AW-1:0] a);
    bit any = 1'b0;
    for (int m = 0; m < NC; m++)
      if (m_sel[m] && a >= m_lo[m] && a <= m_hi[m]) any = 1'b1;
    return bb_enable && (m_mode ? any : !any);
  endfunction

  task automatic dbg(input bit wr, input logic [11:0] ofs, input logic [31:0] wd, input string req);
    bit e;
    logic [31:0] er;
    e = exp_err(wr, ofs);
    er = (!wr && !e) ? exp_rd(ofs) : 32'h0;
    @(negedge clk);
    dbg_req_valid = 1'b1; dbg_req_write = wr; dbg_req_ofs = ofs; dbg_req_wdata = wd;
    @(negedge clk);
    dbg_req_valid = 1'b0;
    chk(dbg_rsp_valid == 1'b1, "R9 rsp_valid", 32'(dbg_rsp_valid), 32'h1);
    chk(dbg_rsp_err == e, req, 32'(dbg_rsp_err), 32'(e));
    if (!wr) chk(dbg_rsp_rdata == er, req, dbg_rsp_rdata, er);
    if (wr && !e) begin
      if (ofs == 12'h03C) begin
        m_sel = wd[NC-1:0];
        m_mode = wd[8];
      end else if (ofs[2]) m_hi[int'(ofs - 12'h100) / 8] = wd[AW-1:0];
      else m_lo[int'(ofs - 12'h100) / 8] = wd[AW-1:0];
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input string req);
    bit e;
    e = model_active(a);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R10 out_valid", 32'(out_valid), 32'h1);
    chk(out_active == e, req, 32'(out_active), 32'(e));
  endtask

  task automatic set_bounds(input int m, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    dbg(1'b1, 12'(12'h100 + 8*m), lo, "R6 write lo");
    dbg(1'b1, 12'(12'h104 + 8*m), hi, "R6 write hi");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < NC; m++) begin m_lo[m] = '0; m_hi[m] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 out_valid after reset", 32'(out_valid), 32'h0);
    dbg(1'b0, 12'h03C, 0, "R12 ctrl reset");
    dbg(1'b0, 12'h100, 0, "R12 lo0 reset");
    dbg(1'b0, 12'h104 + 12'(8*(NC-1)), 0, "R12 hi last reset");

    // R4 R5: reserved bits read zero
    dbg(1'b1, 12'h03C, 32'hFFFF_FFFF, "R4 write all ones");
    dbg(1'b0, 12'h03C, 0, "R4 R5 readback");
    chk(dbg_rsp_rdata == 32'h0000_013F, "R4 literal", dbg_rsp_rdata, 32'h13F);

    set_bounds(0, 32'h100, 32'h1FF);
    set_bounds(1, 32'h400, 32'h400);
    dbg(1'b0, 12'h104, 0, "R6 read hi0");

    dbg(1'b1, 12'h03C, 32'h0, "R2 exclude none");
    send(32'h150, "R2 exclude empty active");
    dbg(1'b1, 12'h03C, 32'h001, "R2 exclude cmp0");
    send(32'h0FF, "R1 below lo");
    send(32'h100, "R1 at lo");
    send(32'h1FF, "R1 at hi");
    send(32'h200, "R1 above hi");
    dbg(1'b1, 12'h03C, 32'h103, "R3 include cmp0 cmp1");
    send(32'h400, "R3 single-address range");
    send(32'h401, "R3 outside");
    send(32'h180, "R3 inside cmp0");
    dbg(1'b1, 12'h03C, 32'h100, "R3 include none");
    send(32'h180, "R3 include empty inactive");
    dbg(1'b1, 12'h03C, 32'h1C0, "R5 reserved selects only");
    dbg(1'b0, 12'h03C, 0, "R5 readback");
    send(32'h180, "R5 reserved select no effect");

    dbg(1'b1, 12'h03C, 32'h0, "R11 exclude none");
    bb_enable = 1'b0;
    send(32'h123, "R11 enable off");
    bb_enable = 1'b1;

    dbg(1'b0, 12'h040, 0, "R6 unmapped offset");
    dbg(1'b0, 12'h102, 0, "R6 misaligned bound");
    dbg(1'b0, 12'(12'h100 + 8*NC), 0, "R6 beyond last comparator");
    dbg(1'b1, 12'h000, 32'h1, "R6 write unmapped");

    os_lock = 1'b1;
    dbg(1'b0, 12'h03C, 0, "R7 lock read");
    dbg(1'b1, 12'h03C, 32'h101, "R7 lock write");
    os_lock = 1'b0;
    ext_access_ok = 1'b0;
    dbg(1'b1, 12'h100, 32'h55, "R7 no access write");
    ext_access_ok = 1'b1;
    core_powered = 1'b0;
    dbg(1'b0, 12'h100, 0, "R7 powered down read");
    core_powered = 1'b1;
    dbg(1'b0, 12'h03C, 0, "R7 ctrl unchanged");
    dbg(1'b0, 12'h100, 0, "R7 bound unchanged");

    unit_idle = 1'b0;
    dbg(1'b1, 12'h03C, 32'h101, "R8 busy write ctrl");
    dbg(1'b1, 12'h104, 32'h9, "R8 busy write bound");
    dbg(1'b0, 12'h03C, 0, "R8 busy read ok");
    dbg(1'b0, 12'h104, 0, "R8 bound unchanged");
    unit_idle = 1'b1;
    send(32'h150, "R8 decision unchanged");

    // R10 back-pressure
    dbg(1'b1, 12'h03C, 32'h101, "R10 include cmp0");
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h150;
    @(negedge clk);
    chk(out_valid && out_active, "R10 first result", {out_valid, out_active}, 2'b11);
    chk(in_ready == 1'b0, "R10 in_ready low", 32'(in_ready), 32'h0);
    in_addr = 32'h900;
    @(negedge clk);
    chk(out_valid && out_active, "R10 held", {out_valid, out_active}, 2'b11);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid && !out_active, "R10 second result", {out_valid, out_active}, 2'b10);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 drained", 32'(out_valid), 32'h0);

    for (int r = 0; r < 8; r++) begin
      for (int m = 0; m < NC; m++) begin
        logic [AW-1:0] lo;
        lo = $urandom % 512;
        set_bounds(m, lo, lo + ($urandom % 128));
      end
      dbg(1'b1, 12'h03C, $urandom & 32'h1FF, "R2 R3 random ctrl");
      bb_enable = ($urandom % 8) != 0;
      for (int k = 0; k < 150; k++) send($urandom % 768, "R1 R2 R3 random address");
      bb_enable = 1'b1;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule